// File: doc/BRIEF.md
# Partial Reconfiguration Control Sequencer

This block runs one partial reconfiguration event on a single region of a device. A bus master writes a control word to a small register window. Bit 0 of that word starts an event and bit 1 asks for a two-pass (double) rewrite. While the event runs, the sequencer raises a freeze output so the region's neighbours ignore it. It accepts configuration words on a parallel valid/ready port and passes them to a configuration sink. The sink is modelled at the block's edge by a data/strobe pair and by done and fault inputs.

The sink takes at most one word every `CDRATIO` clocks, and the data port's ready signal enforces that spacing. A 3-bit status output reports progress. Once the event finishes or fails, the final code stays latched until the next event starts. A JTAG debug input, while high, makes the sequencer ignore every bus write.

Top module: `prcfg_sequencer`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block returns to idle: `freeze` is 0, `status` is 000, `pr_ready` is 0, and the control word reads back as 0. This holds even when reset arrives in the middle of an event.
- R2: A write to offset 1 while idle sets bit 0 (start) of the control word, and a read sees it one cycle later. On the next edge the event is accepted: `freeze` goes to 1, `status` becomes 100 (in progress) and the start bit clears itself.
- R3: In single-pass mode, the first `sink_done` pulse ends the event. At the edge that samples it, `freeze` drops to 0 and `status` becomes 101 (success).
- R4: When control bit 1 was set with the start bit (control word 0x0003), the event needs two `sink_done` pulses. After the first pulse `freeze` stays 1 and `status` stays 100.
- R5: A high level on `dbl_req` at any cycle from acceptance until `freeze` falls turns the event into a double pass. A `dbl_req` level while idle has no effect on the next event.
- R6: Sink faults end the event with `freeze` falling at the same edge. The status codes are: `sink_crc_err` gives 010, `sink_incompat` gives 011, `sink_err` gives 001. If several faults arrive together, they take priority in that order. Fault codes and the success code are held against later `sink_done` or fault pulses until a new event is accepted.
- R7: Control-word writes while an event is in progress are ignored. They neither start another event nor change the pass mode.
- R8: While `jtag_dbg` is 1, bus writes are ignored.
- R9: `pr_ready` is 1 only during an event and only when the ratio counter allows it. Transfers occur at most once every `CDRATIO` clocks, and exactly once per `CDRATIO` clocks while `pr_valid` stays high. Each transfer shows `pr_data` unchanged on `sink_data`, with `sink_strobe` high in the same cycle.
- R10: A read at offset 0 returns the current status code in bits 2:0. A read at offset 1 returns start in bit 0 and double in bit 1. Other offsets read 0.
- R11: `DATA_W` is one of 1, 2, 4, 8, 16 or 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| jtag_dbg | input | 1 | Debug mode; blocks bus writes |
| dbl_req | input | 1 | Double-pass request, honoured during an event |
| pr_data | input | DATA_W | Configuration word |
| pr_valid | input | 1 | Configuration word valid |
| pr_ready | output | 1 | Sequencer can take a word this cycle |
| sink_data | output | DATA_W | Word forwarded to the sink |
| sink_strobe | output | 1 | Sink capture strobe |
| sink_done | input | 1 | Sink finished one pass |
| sink_crc_err | input | 1 | Sink reports a CRC fault |
| sink_incompat | input | 1 | Sink reports an incompatible image |
| sink_err | input | 1 | Sink reports a generic fault |
| freeze | output | 1 | Region isolation during an event |
| status | output | 3 | Event state code |

## Verification
The hardest situation to reach is a double pass that is not requested in the control word but promoted by `dbl_req` in the middle of an event. The first `sink_done` must then keep the region frozen. The stimulus table starts an event with 0x0001, pulses `dbl_req` once after `freeze` rises and then delivers two done pulses. A separate directed case drives `dbl_req` while idle and shows that the next single-pass event still ends on the first done. Writes during an event and under debug mode are checked by reading the control word back, and by counting the done pulses needed to end the event that follows.

// File: rtl/prcfg_pkg.sv
// Shared types for the reconfiguration sequencer.
// Assumes: status codes are visible to software, so their values are fixed.
package prcfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'b000,
        ST_ERR      = 3'b001,
        ST_CRC      = 3'b010,
        ST_INCOMPAT = 3'b011,
        ST_BUSY     = 3'b100,
        ST_OK       = 3'b101
    } pr_status_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } pr_phase_e;

    localparam int STAT_OFS = 0;
    localparam int CTRL_OFS = 1;
    localparam int BUS_W    = 16;
endpackage

// File: rtl/prcfg_csr.sv
// Register window: holds the start and double bits of the control word.
// Serves reads of the status and control offsets.
// Assumes: writes are dropped under debug mode or while busy;
// acceptance by the controller clears the start bit.
module prcfg_csr
    import prcfg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              jtag_dbg,
    input  logic              busy,
    input  logic              accept,
    input  logic [2:0]        status,
    output logic              start_q,
    output logic              dbl_q
);
    logic wr_en;

    // Qualify a write: right offset, not in debug mode, no event running.
    always_comb wr_en = bus_wr && !jtag_dbg && !busy && (bus_addr == ADDR_W'(CTRL_OFS));

    // Hold the control bits; acceptance wins over a write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            dbl_q   <= 1'b0;
        end else if (accept) begin
            start_q <= 1'b0;
        end else if (wr_en) begin
            start_q <= bus_wdata[0];
            dbl_q   <= bus_wdata[1];
        end
    end

    // Read multiplexer for the two offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(STAT_OFS))
            bus_rdata[2:0] = status;
        else if (bus_addr == ADDR_W'(CTRL_OFS))
            bus_rdata[1:0] = {dbl_q, start_q};
    end

    a_r8_debug_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_dbg && bus_wr && !start_q) |=> !start_q)
        else $error("R8 write during debug set start");

    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr) |=> !start_q)
        else $error("R7 write during event set start");
endmodule

// File: rtl/prcfg_ctrl.sv
// Event sequencer: accepts a start and holds freeze for the event.
// Counts one or two done pulses and latches the final status code.
// Assumes: sink fault and done inputs are single-cycle pulses
// synchronous to clk.
module prcfg_ctrl
    import prcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_q,
    input  logic       dbl_q,
    input  logic       dbl_req,
    input  logic       sink_done,
    input  logic       sink_crc_err,
    input  logic       sink_incompat,
    input  logic       sink_err,
    output logic       accept,
    output logic       busy,
    output logic       freeze,
    output logic [2:0] status
);
    pr_phase_e  phase;
    pr_status_e stat_q;
    logic       pass_q;
    logic       dbl_mode;
    logic       dbl_eff;

    // An event is accepted only from idle.
    always_comb accept = (phase == PH_IDLE) && start_q;
    // The pin request counts in the same cycle it appears.
    always_comb dbl_eff = dbl_mode || dbl_req;

    // Phase, pass count, double flag and latched status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            stat_q   <= ST_IDLE;
            pass_q   <= 1'b0;
            dbl_mode <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (accept) begin
                    phase    <= PH_RUN;
                    stat_q   <= ST_BUSY;
                    pass_q   <= 1'b0;
                    dbl_mode <= dbl_q || dbl_req;
                end
                PH_RUN: begin
                    if (dbl_req) dbl_mode <= 1'b1;
                    if (sink_crc_err) begin
                        stat_q <= ST_CRC;
                        phase  <= PH_IDLE;
                    end else if (sink_incompat) begin
                        stat_q <= ST_INCOMPAT;
                        phase  <= PH_IDLE;
                    end else if (sink_err) begin
                        stat_q <= ST_ERR;
                        phase  <= PH_IDLE;
                    end else if (sink_done) begin
                        if (dbl_eff && !pass_q) begin
                            pass_q <= 1'b1;
                        end else begin
                            stat_q <= ST_OK;
                            phase  <= PH_IDLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Freeze and busy follow the phase register directly.
    always_comb begin
        busy   = (phase == PH_RUN);
        freeze = (phase == PH_RUN);
        status = stat_q;
    end

    a_r2_freeze_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze) |-> $past(start_q))
        else $error("R2 freeze rose without start");

    a_r2_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (status == ST_BUSY))
        else $error("R2 frozen without busy code");

    a_r6_final_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !start_q) |=> $stable(status))
        else $error("R6 final code changed without start");

    a_r4_second_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && dbl_mode && !pass_q && sink_done && !sink_crc_err && !sink_incompat && !sink_err)
        |=> freeze)
        else $error("R4 first done ended a double event");
endmodule

// File: rtl/prcfg_ratio.sv
// Data pacer: opens ready once every CDRATIO clocks during an event and
// passes accepted words straight to the sink.
// Assumes: the counter restarts at zero for each new event.
module prcfg_ratio #(
    parameter int DATA_W  = 8,
    parameter int CDRATIO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] pr_data,
    input  logic              pr_valid,
    output logic              pr_ready,
    output logic [DATA_W-1:0] sink_data,
    output logic              sink_strobe
);
    localparam int CNT_W = (CDRATIO > 1) ? $clog2(CDRATIO) : 1;

    // Forward a word in the cycle it is accepted.
    always_comb begin
        sink_strobe = pr_valid && pr_ready;
        sink_data   = pr_data;
    end

    generate
        if (CDRATIO == 1) begin : g_full_rate
            // Every cycle of an event can carry a word.
            always_comb pr_ready = busy;
        end else begin : g_paced
            logic [CNT_W-1:0] gap_q;

            // Reload after each transfer and count down to the next slot.
            always_ff @(posedge clk) begin
                if (!rst_n || !busy) gap_q <= '0;
                else if (sink_strobe) gap_q <= CNT_W'(CDRATIO - 1);
                else if (gap_q != '0) gap_q <= gap_q - 1'b1;
            end

            // Ready opens only when the gap has run out.
            always_comb pr_ready = busy && (gap_q == '0);

            a_r9_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                sink_strobe |=> !sink_strobe)
                else $error("R9 back-to-back transfers");
        end
    endgenerate

    a_r9_ready_in_event: assert property (@(posedge clk) disable iff (!rst_n)
        pr_ready |-> busy)
        else $error("R9 ready outside event");

    initial begin
        a_r11_width: assert (DATA_W == 1 || DATA_W == 2 || DATA_W == 4 ||
                             DATA_W == 8 || DATA_W == 16 || DATA_W == 32)
            else $error("R11 unsupported data width");
    end
endmodule

// File: rtl/prcfg_sequencer.sv
// Top of the reconfiguration sequencer.
// Joins the register window, the event controller and the data pacer.
// Assumes: one clock domain; synchronous active-low reset.
module prcfg_sequencer
    import prcfg_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int CDRATIO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              jtag_dbg,
    input  logic              dbl_req,
    input  logic [DATA_W-1:0] pr_data,
    input  logic              pr_valid,
    output logic              pr_ready,
    output logic [DATA_W-1:0] sink_data,
    output logic              sink_strobe,
    input  logic              sink_done,
    input  logic              sink_crc_err,
    input  logic              sink_incompat,
    input  logic              sink_err,
    output logic              freeze,
    output logic [2:0]        status
);
    logic start_q, dbl_q, accept, busy;

    prcfg_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .jtag_dbg(jtag_dbg),
        .busy(busy), .accept(accept), .status(status),
        .start_q(start_q), .dbl_q(dbl_q)
    );

    prcfg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_q(start_q), .dbl_q(dbl_q),
        .dbl_req(dbl_req), .sink_done(sink_done), .sink_crc_err(sink_crc_err),
        .sink_incompat(sink_incompat), .sink_err(sink_err),
        .accept(accept), .busy(busy), .freeze(freeze), .status(status)
    );

    prcfg_ratio #(.DATA_W(DATA_W), .CDRATIO(CDRATIO)) u_ratio (
        .clk(clk), .rst_n(rst_n), .busy(busy), .pr_data(pr_data),
        .pr_valid(pr_valid), .pr_ready(pr_ready), .sink_data(sink_data),
        .sink_strobe(sink_strobe)
    );

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!freeze && status == 3'b000 && !pr_ready))
        else $error("R1 reset did not idle");
endmodule

// File: tb/tb_prcfg_sequencer.sv
module tb_prcfg_sequencer;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int CDR    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic jtag_dbg = 1'b0, dbl_req = 1'b0;
    logic [DATA_W-1:0] pr_data = '0;
    logic pr_valid = 1'b0, pr_ready;
    logic [DATA_W-1:0] sink_data;
    logic sink_strobe;
    logic sink_done = 1'b0, sink_crc_err = 1'b0, sink_incompat = 1'b0, sink_err = 1'b0;
    logic freeze;
    logic [2:0] status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    prcfg_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CDRATIO(CDR)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .jtag_dbg(jtag_dbg),
        .dbl_req(dbl_req), .pr_data(pr_data), .pr_valid(pr_valid),
        .pr_ready(pr_ready), .sink_data(sink_data), .sink_strobe(sink_strobe),
        .sink_done(sink_done), .sink_crc_err(sink_crc_err),
        .sink_incompat(sink_incompat), .sink_err(sink_err),
        .freeze(freeze), .status(status)
    );

    always #5 clk = ~clk;

    // Vector: {ctrl[1:0], pin, fault[1:0], exp_status[2:0], dones[1:0]}
    // fault: 0 none, 1 crc, 2 incompatible, 3 generic
    localparam logic [9:0] VEC [6] = '{
        {2'b01, 1'b0, 2'd0, 3'b101, 2'd1},
        {2'b11, 1'b0, 2'd0, 3'b101, 2'd2},
        {2'b01, 1'b1, 2'd0, 3'b101, 2'd2},
        {2'b01, 1'b0, 2'd1, 3'b010, 2'd0},
        {2'b11, 1'b0, 2'd2, 3'b011, 2'd0},
        {2'b01, 1'b0, 2'd3, 3'b001, 2'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int ofs, input logic [15:0] val);
        bus_addr  = ADDR_W'(ofs);
        bus_wdata = val;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read_at(input int ofs, output logic [15:0] val);
        bus_addr = ADDR_W'(ofs);
        #1;
        val = bus_rdata;
    endtask

    task automatic pulse_done();
        sink_done = 1'b1;
        @(negedge clk);
        sink_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below 50000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] rd;
        int strobes;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 freeze", freeze, 0);
        chk("R1 status", status, 0);
        chk("R1 ready", pr_ready, 0);
        read_at(1, rd);
        chk("R1 control", rd, 0);

        for (int i = 0; i < 6; i++) begin
            logic [9:0] v;
            v = VEC[i];
            bus_write(1, {14'b0, v[9:8]});
            read_at(1, rd);
            chk("R2 start bit set", rd[0], 1);
            chk("R2 not yet frozen", freeze, 0);
            @(negedge clk);
            chk("R2 freeze", freeze, 1);
            chk("R2 busy code", status, 3'b100);
            read_at(1, rd);
            chk("R2 start self-clear", rd[0], 0);
            if (v[7]) begin
                // R5 promotion by the pin mid-event
                dbl_req = 1'b1;
                @(negedge clk);
                dbl_req = 1'b0;
            end
            if (v[6:5] != 0) begin
                case (v[6:5])
                    2'd1: sink_crc_err  = 1'b1;
                    2'd2: sink_incompat = 1'b1;
                    default: sink_err   = 1'b1;
                endcase
                @(negedge clk);
                {sink_crc_err, sink_incompat, sink_err} = 3'b000;
                chk("R6 fault code", status, v[4:2]);
                chk("R6 freeze drop", freeze, 0);
            end else begin
                for (int d = 0; d < int'(v[1:0]); d++) begin
                    chk("R4 frozen before last done", freeze, 1);
                    chk("R4 busy before last done", status, 3'b100);
                    pulse_done();
                end
                chk("R3 success code", status, v[4:2]);
                chk("R3 freeze drop", freeze, 0);
            end
            read_at(0, rd);
            chk("R10 status read", rd[2:0], v[4:2]);
            @(negedge clk);
        end

        // R6 fault priority: all three together give CRC
        bus_write(1, 16'h0001);
        @(negedge clk);
        {sink_crc_err, sink_incompat, sink_err} = 3'b111;
        @(negedge clk);
        {sink_crc_err, sink_incompat, sink_err} = 3'b000;
        chk("R6 priority", status, 3'b010);
        // R6 hold against later pulses
        pulse_done();
        sink_err = 1'b1;
        @(negedge clk);
        sink_err = 1'b0;
        chk("R6 code held", status, 3'b010);
        chk("R6 stays unfrozen", freeze, 0);

        // R8 writes blocked under debug
        jtag_dbg = 1'b1;
        bus_write(1, 16'h0003);
        @(negedge clk);
        chk("R8 no freeze", freeze, 0);
        read_at(1, rd);
        chk("R8 control unchanged", rd[1:0], 2'b00);
        jtag_dbg = 1'b0;

        // R5 pin while idle has no effect
        dbl_req = 1'b1;
        @(negedge clk);
        dbl_req = 1'b0;
        bus_write(1, 16'h0001);
        @(negedge clk);
        pulse_done();
        chk("R5 idle pin ignored", status, 3'b101);
        chk("R5 idle pin freeze", freeze, 0);

        // R7 write during event ignored
        bus_write(1, 16'h0001);
        @(negedge clk);
        bus_write(1, 16'h0003);
        read_at(1, rd);
        chk("R7 start not set", rd[0], 0);
        chk("R7 still frozen", freeze, 1);
        pulse_done();
        chk("R7 single pass kept", status, 3'b101);

        // R9 ready outside an event
        pr_valid = 1'b1;
        #1;
        chk("R9 ready idle", pr_ready, 0);
        chk("R9 no strobe idle", sink_strobe, 0);
        // R9 pacing during an event
        bus_write(1, 16'h0001);
        @(negedge clk);
        strobes = 0;
        for (int k = 0; k < 16; k++) begin
            pr_data = DATA_W'(k * 7 + 3);
            #1;
            if (sink_strobe) begin
                strobes++;
                chk("R9 data forwarded", sink_data, pr_data);
            end
            @(negedge clk);
        end
        chk("R9 transfer count", strobes, 16 / CDR);
        pr_valid = 1'b0;
        pulse_done();

        // R1 reset in the middle of an event
        bus_write(1, 16'h0003);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid-event freeze", freeze, 0);
        chk("R1 mid-event status", status, 0);
        read_at(1, rd);
        chk("R1 mid-event control", rd, 0);

        finish_run();
    end
endmodule